// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using two levels of state. The first level is a shift register of recent branch outcomes across the whole program. The second level is a table of 2-bit saturating counters. The fetch unit presents the word-address bits of the branch. The block XORs them with the history to pick one counter. The top bit of that counter is the guess, returned in the same cycle as the request.

The fetch unit keeps the table index that came with the prediction and carries it down the pipeline. When the branch retires, that index and the real outcome come back on the update port. The update trains exactly the counter that made the guess and shifts the outcome into the history. Because the stored index is used, history that moved on in the meantime cannot send the training to the wrong counter.

Top module: `ghist_dir_pred`

## Requirements
- R1: After reset the history is all zeros and every counter holds 2 (weakly taken), so every lookup predicts taken and its index equals the presented address bits.
- R2: The lookup index `pred_idx` is the bitwise XOR of `fetch_pc` and the history register. When the history is narrower than the index, it is zero-extended at the top.
- R3: `pred_taken` is bit 1 of the counter selected by `pred_idx`. 1 means taken and 0 means not taken. It is combinational in the same cycle as `fetch_pc`.
- R4: A valid update with `upd_taken` = 1 raises the counter at `upd_idx` by one, saturating at 3. The new value is visible from the next cycle.
- R5: A valid update with `upd_taken` = 0 lowers the counter at `upd_idx` by one, saturating at 0. The new value is visible from the next cycle.
- R6: An update changes no counter other than the one at `upd_idx`. A cycle with `upd_valid` = 0 changes no counter.
- R7: Each valid update shifts `upd_taken` into bit 0 of the history and drops the oldest bit. The history holds its value in cycles with `upd_valid` = 0.
- R8: A lookup that selects the same index as an update in the same cycle returns the counter value from before that update.
- R9: A counter at 3 still predicts taken after one not-taken update and predicts not taken only after the second one. The same holds in the other direction from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | IDX_W | Word-address bits of the branch being fetched |
| pred_idx | output | IDX_W | Table index used for this lookup, to be carried to retire |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A branch retires this cycle |
| upd_idx | input | IDX_W | Index that branch was predicted with |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
Lookups have no register on their path, so `pred_idx` and `pred_taken` are due in the cycle `fetch_pc` is driven. The effects of an update, on both a counter and the history, appear one edge later. The bench drives inputs just after a rising edge and compares both outputs with a behavioural model at the falling edge. It advances the model only after that comparison, which makes every check see the state from before the current cycle's update. Directed sequences steer the address so that a chosen counter is read back after each step of saturation and hysteresis. History movement is observed through `pred_idx` while an all-zero address is presented.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN    = 2'd0;
    localparam ctr_t CTR_MAX    = 2'd3;
    localparam ctr_t CTR_WEAK_T = 2'd2;

    // saturating step of one 2-bit counter
    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        if (taken) begin
            r = (c == CTR_MAX) ? c : c + 2'd1;
        end else begin
            r = (c == CTR_MIN) ? c : c - 2'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ghp_hist_reg.sv
module ghp_hist_reg #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] hist
);

    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.bits = {st_q.bits[HIST_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist = st_q.bits;

    assert_hist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist[0] == $past(upd_taken)) &&
                      (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

endmodule

// File: rtl/ghp_index_hash.sv
module ghp_index_hash #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic [IDX_W-1:0]  pc_bits,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    generate
        if (HIST_W == IDX_W) begin : g_full
            assign idx = pc_bits ^ hist;
        end else begin : g_ext
            localparam int PAD_W = IDX_W - HIST_W;
            assign idx = pc_bits ^ {{PAD_W{1'b0}}, hist};
        end
    endgenerate

endmodule

// File: rtl/ghp_pht.sv
module ghp_pht
    import ghp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] ctr;
    } pht_state_t;

    pht_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.ctr[upd_idx] = ctr_step(st_q.ctr[upd_idx], upd_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctr <= {DEPTH{CTR_WEAK_T}};
        end else begin
            st_q <= st_d;
        end
    end

    // read reflects registered state: same-cycle update is not forwarded
    assign rd_taken = st_q.ctr[rd_idx][1];

    assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && st_q.ctr[upd_idx] != CTR_MAX) |=>
        st_q.ctr[$past(upd_idx)] == $past(st_q.ctr[upd_idx]) + 2'd1);

    assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && st_q.ctr[upd_idx] == CTR_MAX) |=>
        st_q.ctr[$past(upd_idx)] == CTR_MAX);

    assert_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && st_q.ctr[upd_idx] != CTR_MIN) |=>
        st_q.ctr[$past(upd_idx)] == $past(st_q.ctr[upd_idx]) - 2'd1);

    assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && st_q.ctr[upd_idx] == CTR_MIN) |=>
        st_q.ctr[$past(upd_idx)] == CTR_MIN);

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(st_q.ctr));

endmodule

// File: rtl/ghist_dir_pred.sv
module ghist_dir_pred #(
    parameter int HIST_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] fetch_pc,
    output logic [IDX_W-1:0] pred_idx,
    output logic             pred_taken,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    logic [HIST_W-1:0] hist;

    initial begin
        assert_cfg_R2: assert (HIST_W >= 2 && HIST_W <= IDX_W);
    end

    ghp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_taken (upd_taken),
        .hist      (hist)
    );

    ghp_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hash (
        .pc_bits (fetch_pc),
        .hist    (hist),
        .idx     (pred_idx)
    );

    ghp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (pred_idx),
        .rd_taken  (pred_taken),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_taken (upd_taken)
    );

endmodule

// File: tb/ghist_dir_pred_tb_top.sv
module ghist_dir_pred_tb_top;

    localparam int HIST_W = 8;
    localparam int IDX_W  = 8;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int HMASK  = (1 << HIST_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] fetch_pc = '0;
    logic [IDX_W-1:0] pred_idx;
    logic             pred_taken;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_idx = '0;
    logic             upd_taken = 1'b0;

    always #2 clk = ~clk;

    ghist_dir_pred #(.HIST_W(HIST_W), .IDX_W(IDX_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .pred_idx   (pred_idx),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_idx),
        .upd_taken  (upd_taken)
    );

    int checks = 0;
    int fails  = 0;
    int ref_ctr[DEPTH];
    int ref_hist;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive, compare at falling edge, then advance the model
    task automatic step(string tag, int pc, bit uv, int ui, bit ut);
        int eidx;
        fetch_pc  = pc[IDX_W-1:0];
        upd_valid = uv;
        upd_idx   = ui[IDX_W-1:0];
        upd_taken = ut;
        @(negedge clk);
        eidx = (pc ^ ref_hist) & (DEPTH - 1);
        chk({tag, " idx R2"}, int'(pred_idx), eidx);
        chk({tag, " pred R3"}, int'(pred_taken), (ref_ctr[eidx] >= 2) ? 1 : 0);
        if (uv) begin
            if (ut) ref_ctr[ui] = (ref_ctr[ui] == 3) ? 3 : ref_ctr[ui] + 1;
            else    ref_ctr[ui] = (ref_ctr[ui] == 0) ? 0 : ref_ctr[ui] - 1;
            ref_hist = ((ref_hist << 1) | int'(ut)) & HMASK;
        end
        @(posedge clk);
        #1;
    endtask

    // read counter at index x with no update and compare with a fixed value
    task automatic peek(string tag, int x, int exp_pred);
        int pc;
        pc = x ^ ref_hist;
        fetch_pc  = pc[IDX_W-1:0];
        upd_valid = 1'b0;
        @(negedge clk);
        chk(tag, int'(pred_taken), exp_pred);
        @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_ctr[i] = 2;
        ref_hist = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state seen at every address
        for (int p = 0; p < DEPTH; p++) step("R1", p, 1'b0, 0, 1'b0);

        // R4 / R9: saturate high, then two not-taken flip it
        for (int k = 0; k < 3; k++) step("R4", 'h5A ^ ref_hist, 1'b1, 'h5A, 1'b1);
        peek("R4 saturated high", 'h5A, 1);
        step("R9", 0, 1'b1, 'h5A, 1'b0);
        peek("R9 one not-taken keeps taken", 'h5A, 1);
        step("R9", 0, 1'b1, 'h5A, 1'b0);
        peek("R9 second not-taken flips", 'h5A, 0);

        // R5 / R9: saturate low, then two taken flip it
        for (int k = 0; k < 3; k++) step("R5", 0, 1'b1, 'h5A, 1'b0);
        peek("R5 saturated low", 'h5A, 0);
        step("R9", 0, 1'b1, 'h5A, 1'b1);
        peek("R9 one taken keeps not-taken", 'h5A, 0);
        step("R9", 0, 1'b1, 'h5A, 1'b1);
        peek("R9 second taken flips", 'h5A, 1);

        // R8: read and update same index, same cycle -> old value
        step("R5", 0, 1'b1, 'h33, 1'b0);
        step("R8 same-cycle", 'h33 ^ ref_hist, 1'b1, 'h33, 1'b0);
        peek("R8 update lands next cycle", 'h33, 0);

        // R7: history through pred_idx with zero address; idle holds it
        step("R7", 0, 1'b1, 1, 1'b1);
        step("R7", 0, 1'b1, 2, 1'b0);
        step("R7", 0, 1'b1, 3, 1'b1);
        for (int k = 0; k < 4; k++) step("R7 idle hold", 0, 1'b0, 0, 1'b1);

        // R6 and everything else: random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            step("R6 random", int'($urandom_range(DEPTH - 1)),
                 bit'($urandom_range(1)), int'($urandom_range(DEPTH - 1)),
                 bit'($urandom_range(1)));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule